// File: doc/BRIEF.md
# Dynamic Phase Alignment Selector

This block sits behind a multi-phase front end that samples a serial line at eight evenly spaced clock phases, 45 degrees apart, in every bit period. Each enabled cycle it takes one 8-sample vector. It counts where the data transitions fall between neighbouring phases and steers a phase pointer toward the sample point that lies farthest from those edges. The data bit seen at the chosen phase is passed on as the retimed output. With eight phases, the chosen point can be off by at most 1/8 of a unit interval.

No training pattern is needed. The block tracks continuously from ordinary traffic, provided that traffic has transitions. A hold input freezes the phase pointer. A dedicated alignment reset clears all learned state, after which the block retrains. A sticky lock flag reports the first lock after reset. A one-cycle pulse marks the same moment, so that a downstream elastic buffer can be cleared.

Top module: `dps_phase_select`

## Requirements
- R1: After `rst` or `dpa_rst` has been high at a clock edge, `phase_sel` is 0 and `data_out`, `locked` and `lock_pulse` are all 0.
- R2: Gap k (k = 0..6) counts one transition when `samp[k]` differs from `samp[k+1]` in the same vector. Gap 7 counts one when `samp[7]` of the previous enabled vector differs from `samp[0]` of the current one. Counts are gathered over windows of WIN enabled cycles. The window's best phase is (busiest gap + 4) mod 8. On equal counts the lowest gap index wins.
- R3: The phase pointer moves by at most one step per window, along the shorter way round toward the best phase. When the target is exactly 4 steps away, the pointer moves upward (index + 1 mod 8).
- R4: The pointer moves only when two consecutive non-empty windows give the same best phase and that phase differs from the current one. Windows that alternate between two different best phases leave the pointer still.
- R5: A window with no transitions at any gap produces no decision. It also breaks the run of consecutive matching windows.
- R6: While `hold` is high at a window's decision, `phase_sel` does not change.
- R7: `locked` rises after two consecutive non-empty windows give the same best phase, whether or not `hold` is high. It stays high until a reset.
- R8: `lock_pulse` is high for exactly one cycle, the cycle in which `locked` first becomes 1 after a reset.
- R9: On each cycle with `en` high, `data_out` takes `samp[phase_sel]` at the next edge.
- R10: With `en` low, nothing is counted, the window does not advance, and `data_out` holds its value.
- R11: `dpa_rst` discards all learned state. After it, a single window cannot produce lock, and realignment starts again from phase 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one enabled cycle per bit period |
| rst | input | 1 | Synchronous active-high system reset |
| dpa_rst | input | 1 | Synchronous active-high alignment reset, forces retraining |
| en | input | 1 | Sample vector valid this cycle |
| hold | input | 1 | Freeze the phase pointer |
| samp | input | 8 | Samples of one bit period; bit k taken at phase k |
| phase_sel | output | 3 | Selected phase index |
| data_out | output | 1 | Retimed data bit taken at the selected phase |
| locked | output | 1 | Sticky initial-lock flag |
| lock_pulse | output | 1 | One-cycle pulse on first lock |

## Verification
The bench drives an alternating bit stream whose edge sits at a chosen gap, and sweeps that gap over several positions including the wrap-around gap 7. This separates the target arithmetic and the choice of the shorter direction, including the 4-step tie. A constant two-edge vector with equal counts at two gaps exposes the tie rule for the busiest gap. A stream with no transitions shows that empty windows neither move the pointer nor lock. Windows that alternate between two edge positions distinguish real hysteresis from a single-window decision. Hold, enable-low gaps carrying foreign edges, and alignment reset in mid-track are each checked against a bench model of the window-by-window pointer, along with single-phase data vectors that reveal which sample reaches the output.

// File: rtl/dps_pkg.sv
package dps_pkg;
  localparam int unsigned PH_N = 8;
  localparam int unsigned PH_W = $clog2(PH_N);

  typedef logic [PH_W-1:0] phase_t;

  // One step from cur toward tgt on a circle of PH_N phases; half-way ties go up.
  function automatic phase_t step_toward(input phase_t cur, input phase_t tgt);
    phase_t diff;
    diff = tgt - cur;
    if (diff == '0) return cur;
    else if (int'(diff) <= int'(PH_N / 2)) return cur + phase_t'(1);
    else return cur - phase_t'(1);
  endfunction
endpackage

// File: rtl/dps_trans_hist.sv
module dps_trans_hist
  import dps_pkg::*;
#(
  parameter int unsigned WIN   = 64,
  parameter int unsigned CNT_W = $clog2(WIN + 1)
) (
  input  logic                           clk,
  input  logic                           clr,
  input  logic                           en,
  input  logic [PH_N-1:0]                samp,
  output logic                           win_done,
  output logic [PH_N-1:0][CNT_W-1:0]     win_cnt
);
  localparam int unsigned POS_W = (WIN > 1) ? $clog2(WIN) : 1;
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(WIN - 1);

  logic [PH_N-1:0]  trans;
  logic             prev_last;
  logic             prev_vld;
  logic [POS_W-1:0] win_pos;
  logic             last_slot;

  assign last_slot = (win_pos == POS_LAST);

  genvar k;
  generate
    for (k = 0; k < PH_N - 1; k++) begin : g_inner
      assign trans[k] = samp[k] ^ samp[k+1];
    end
  endgenerate
  assign trans[PH_N-1] = prev_vld & (prev_last ^ samp[0]);

  always_ff @(posedge clk) begin
    if (clr) begin
      win_pos   <= '0;
      win_done  <= 1'b0;
      prev_last <= 1'b0;
      prev_vld  <= 1'b0;
    end else begin
      win_done <= 1'b0;
      if (en) begin
        prev_last <= samp[PH_N-1];
        prev_vld  <= 1'b1;
        if (last_slot) begin
          win_pos  <= '0;
          win_done <= 1'b1;
        end else begin
          win_pos <= win_pos + POS_W'(1);
        end
      end
    end
  end

  generate
    for (k = 0; k < PH_N; k++) begin : g_gap
      logic [CNT_W-1:0] acc;
      always_ff @(posedge clk) begin
        if (clr) begin
          acc        <= '0;
          win_cnt[k] <= '0;
        end else if (en) begin
          if (last_slot) begin
            win_cnt[k] <= acc + CNT_W'(trans[k]);
            acc        <= '0;
          end else begin
            acc <= acc + CNT_W'(trans[k]);
          end
        end
      end
    end
  endgenerate
endmodule

// File: rtl/dps_best_pick.sv
module dps_best_pick
  import dps_pkg::*;
#(
  parameter int unsigned CNT_W = 7
) (
  input  logic [PH_N-1:0][CNT_W-1:0] win_cnt,
  output phase_t                     best_phase,
  output logic                       nonempty
);
  phase_t           best_gap;
  logic [CNT_W-1:0] best_val;
  logic [PH_N-1:0]  any_hit;

  genvar k;
  generate
    for (k = 0; k < PH_N; k++) begin : g_hit
      assign any_hit[k] = |win_cnt[k];
    end
  endgenerate

  always_comb begin
    best_gap = '0;
    best_val = win_cnt[0];
    for (int i = 1; i < int'(PH_N); i++) begin
      if (win_cnt[i] > best_val) begin
        best_val = win_cnt[i];
        best_gap = phase_t'(i);
      end
    end
  end

  assign best_phase = best_gap + phase_t'(PH_N / 2);
  assign nonempty   = |any_hit;
endmodule

// File: rtl/dps_track_ctrl.sv
module dps_track_ctrl
  import dps_pkg::*;
(
  input  logic   clk,
  input  logic   clr,
  input  logic   win_done,
  input  logic   nonempty,
  input  phase_t best_phase,
  input  logic   hold,
  output phase_t phase_sel,
  output logic   locked,
  output logic   lock_pulse
);
  phase_t last_best;
  logic   last_vld;
  logic   repeat_hit;

  assign repeat_hit = last_vld && (last_best == best_phase);

  always_ff @(posedge clk) begin
    if (clr) begin
      phase_sel  <= '0;
      locked     <= 1'b0;
      lock_pulse <= 1'b0;
      last_best  <= '0;
      last_vld   <= 1'b0;
    end else begin
      lock_pulse <= 1'b0;
      if (win_done) begin
        if (nonempty) begin
          if (repeat_hit) begin
            if (!locked) begin
              locked     <= 1'b1;
              lock_pulse <= 1'b1;
            end
            if (!hold && (best_phase != phase_sel))
              phase_sel <= step_toward(phase_sel, best_phase);
          end
          last_best <= best_phase;
          last_vld  <= 1'b1;
        end else begin
          last_vld <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/dps_retime.sv
module dps_retime
  import dps_pkg::*;
(
  input  logic            clk,
  input  logic            clr,
  input  logic            en,
  input  logic [PH_N-1:0] samp,
  input  phase_t          phase_sel,
  output logic            data_out
);
  always_ff @(posedge clk) begin
    if (clr)     data_out <= 1'b0;
    else if (en) data_out <= samp[phase_sel];
  end
endmodule

// File: rtl/dps_phase_select.sv
module dps_phase_select
  import dps_pkg::*;
#(
  parameter int unsigned WIN = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            dpa_rst,
  input  logic            en,
  input  logic            hold,
  input  logic [PH_N-1:0] samp,
  output logic [PH_W-1:0] phase_sel,
  output logic            data_out,
  output logic            locked,
  output logic            lock_pulse
);
  localparam int unsigned CNT_W = $clog2(WIN + 1);

  logic                       clr;
  logic                       win_done;
  logic [PH_N-1:0][CNT_W-1:0] win_cnt;
  phase_t                     best_phase;
  logic                       nonempty;

  assign clr = rst | dpa_rst;

  dps_trans_hist #(.WIN(WIN), .CNT_W(CNT_W)) hist_i (
    .clk(clk), .clr(clr), .en(en), .samp(samp),
    .win_done(win_done), .win_cnt(win_cnt)
  );

  dps_best_pick #(.CNT_W(CNT_W)) pick_i (
    .win_cnt(win_cnt), .best_phase(best_phase), .nonempty(nonempty)
  );

  dps_track_ctrl ctrl_i (
    .clk(clk), .clr(clr), .win_done(win_done), .nonempty(nonempty),
    .best_phase(best_phase), .hold(hold), .phase_sel(phase_sel),
    .locked(locked), .lock_pulse(lock_pulse)
  );

  dps_retime retime_i (
    .clk(clk), .clr(clr), .en(en), .samp(samp),
    .phase_sel(phase_sel), .data_out(data_out)
  );
endmodule

// File: rtl/dps_phase_select_chk.sv
module dps_phase_select_chk
  import dps_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic            dpa_rst,
  input logic            en,
  input logic            hold,
  input logic [PH_N-1:0] samp,
  input logic [PH_W-1:0] phase_sel,
  input logic            data_out,
  input logic            locked,
  input logic            lock_pulse
);
  logic clr;
  assign clr = rst | dpa_rst;

  assert_reset_state_R1: assert property (@(posedge clk)
    clr |=> (phase_sel == '0 && !locked && !lock_pulse && !data_out));

  assert_single_step_R3: assert property (@(posedge clk) disable iff (clr)
    (!$past(clr) && !$stable(phase_sel)) |->
      ((phase_sel - $past(phase_sel)) == PH_W'(1) ||
       ($past(phase_sel) - phase_sel) == PH_W'(1)));

  assert_hold_freeze_R6: assert property (@(posedge clk) disable iff (clr)
    hold |=> $stable(phase_sel));

  assert_lock_sticky_R7: assert property (@(posedge clk) disable iff (clr)
    locked |=> locked);

  assert_pulse_with_lock_R8: assert property (@(posedge clk) disable iff (clr)
    lock_pulse |-> locked);

  assert_pulse_single_R8: assert property (@(posedge clk) disable iff (clr)
    lock_pulse |=> !lock_pulse);

  assert_pulse_first_R8: assert property (@(posedge clk) disable iff (clr)
    (lock_pulse && !$past(clr)) |-> !$past(locked));

  assert_retime_R9: assert property (@(posedge clk) disable iff (clr)
    en |=> (data_out == $past(samp[phase_sel])));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (clr)
    !en |=> $stable(data_out));
endmodule

bind dps_phase_select dps_phase_select_chk chk_i (
  .clk(clk), .rst(rst), .dpa_rst(dpa_rst), .en(en), .hold(hold),
  .samp(samp), .phase_sel(phase_sel), .data_out(data_out),
  .locked(locked), .lock_pulse(lock_pulse)
);

// File: tb/dps_phase_select_tb_top.sv
module dps_phase_select_tb_top;
  localparam int WIN = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       dpa_rst = 1'b0;
  logic       en = 1'b0;
  logic       hold = 1'b0;
  logic [7:0] samp = 8'h00;
  logic [2:0] phase_sel;
  logic       data_out;
  logic       locked;
  logic       lock_pulse;

  int errs = 0;
  int checks = 0;
  int pulses = 0;
  logic bitv = 1'b0;

  // bench model of the pointer, per window
  int   mph = 0;
  int   mlast = 0;
  bit   mlast_vld = 0;
  bit   mlock = 0;

  always #5 clk = ~clk;

  dps_phase_select #(.WIN(WIN)) dut_i (
    .clk(clk), .rst(rst), .dpa_rst(dpa_rst), .en(en), .hold(hold),
    .samp(samp), .phase_sel(phase_sel), .data_out(data_out),
    .locked(locked), .lock_pulse(lock_pulse)
  );

  always @(negedge clk) if (lock_pulse) pulses++;

  task automatic check_eq(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] mkvec(input int g, input logic pb, input logic cb);
    logic [7:0] v;
    for (int i = 0; i < 8; i++) v[i] = (g == 7) ? cb : ((i <= g) ? pb : cb);
    return v;
  endfunction

  task automatic drive(input logic [7:0] v, input logic e);
    @(negedge clk);
    samp = v;
    en   = e;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(samp, 1'b0);
  endtask

  task automatic model_reset();
    mph = 0; mlast = 0; mlast_vld = 0; mlock = 0;
  endtask

  // g >= 0: edge at gap g; g == -1: constant 0x38 (equal counts at gaps 2 and 5); g == -2: constant 0
  task automatic run_win(input int g, input logic h, input int best);
    hold = h;
    for (int i = 0; i < WIN; i++) begin
      logic pb;
      pb = bitv;
      bitv = ~bitv;
      if (g >= 0)       drive(mkvec(g, pb, bitv), 1'b1);
      else if (g == -1) drive(8'b0011_1000, 1'b1);
      else              drive(8'h00, 1'b1);
    end
    idle(3);
    hold = 1'b0;
    if (best >= 0) begin
      if (mlast_vld && mlast == best) begin
        mlock = 1;
        if (best != mph && !h) begin
          int diff;
          diff = (best - mph + 8) % 8;
          mph = (diff <= 4) ? (mph + 1) % 8 : (mph + 7) % 8;
        end
      end
      mlast = best;
      mlast_vld = 1;
    end else begin
      mlast_vld = 0;
    end
  endtask

  task automatic pulse_dpa_rst();
    @(negedge clk);
    dpa_rst = 1'b1;
    en = 1'b0;
    @(negedge clk);
    dpa_rst = 1'b0;
    model_reset();
  endtask

  initial begin
    #2_000_000;
    errs++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int p0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check_eq(phase_sel, 0, "R1 phase after rst");
    check_eq(locked, 0, "R1 locked after rst");
    check_eq(lock_pulse, 0, "R1 pulse after rst");
    check_eq(data_out, 0, "R1 data after rst");

    // R9 / R10 retiming at phase 0
    drive(8'h01, 1'b1);
    drive(8'h00, 1'b0);
    check_eq(data_out, 1, "R9 phase0 bit0 high");
    drive(8'hFE, 1'b1);
    drive(8'hFF, 1'b0);
    check_eq(data_out, 0, "R9 phase0 bit0 low");
    idle(4);
    check_eq(data_out, 0, "R10 data held while en low");

    // R5 empty windows
    pulse_dpa_rst();
    run_win(-2, 1'b0, -1);
    run_win(-2, 1'b0, -1);
    run_win(-2, 1'b0, -1);
    check_eq(phase_sel, 0, "R5 no move on empty windows");
    check_eq(locked, 0, "R5 no lock on empty windows");

    // R2/R3/R7/R8 edge at gap 1 -> target 5, downward path
    pulse_dpa_rst();
    p0 = pulses;
    run_win(1, 1'b0, 5);
    check_eq(locked, mlock, "R7 no lock after one window");
    check_eq(phase_sel, mph, "R4 no move after one window");
    run_win(1, 1'b0, 5);
    check_eq(locked, 1, "R7 lock after two windows");
    check_eq(phase_sel, 7, "R3 first step downward");
    check_eq(pulses - p0, 1, "R8 one pulse at lock");
    run_win(1, 1'b0, 5);
    check_eq(phase_sel, 6, "R3 second step");
    run_win(1, 1'b0, 5);
    run_win(1, 1'b0, 5);
    check_eq(phase_sel, 5, "R2 settled at gap1+4");
    check_eq(pulses - p0, 1, "R8 no further pulses");
    check_eq(locked, 1, "R7 lock stays");

    // R9 at phase 5
    drive(8'b0010_0000, 1'b1);
    drive(8'h00, 1'b0);
    check_eq(data_out, 1, "R9 phase5 bit5 high");
    drive(8'b1101_1111, 1'b1);
    drive(8'hFF, 1'b0);
    check_eq(data_out, 0, "R9 phase5 bit5 low");

    // R11 alignment reset mid-track, then single window
    pulse_dpa_rst();
    @(negedge clk);
    check_eq(phase_sel, 0, "R11 phase cleared");
    check_eq(locked, 0, "R11 lock cleared");
    p0 = pulses;
    run_win(6, 1'b0, 2);
    check_eq(locked, 0, "R11 no lock after one window post reset");

    // R4 alternating windows
    pulse_dpa_rst();
    for (int w = 0; w < 4; w++) run_win((w % 2 == 0) ? 1 : 3, 1'b0, (w % 2 == 0) ? 5 : 7);
    check_eq(phase_sel, 0, "R4 alternating best stays");
    check_eq(locked, 0, "R4 alternating no lock");

    // R6 hold
    pulse_dpa_rst();
    p0 = pulses;
    run_win(6, 1'b0, 2);
    run_win(6, 1'b1, 2);
    check_eq(phase_sel, 0, "R6 held window no move");
    check_eq(locked, 1, "R7 lock under hold");
    run_win(6, 1'b1, 2);
    check_eq(phase_sel, 0, "R6 second held window");
    run_win(6, 1'b0, 2);
    check_eq(phase_sel, 1, "R6 moves after release");
    run_win(6, 1'b0, 2);
    check_eq(phase_sel, 2, "R2 gap6 target");
    check_eq(pulses - p0, 1, "R8 one pulse with hold");

    // R2 tie at gaps 2 and 5 -> gap 2 wins -> target 6
    pulse_dpa_rst();
    run_win(-1, 1'b0, 6);
    run_win(-1, 1'b0, 6);
    check_eq(phase_sel, 7, "R2 tie first step");
    run_win(-1, 1'b0, 6);
    check_eq(phase_sel, 6, "R2 lowest gap wins tie");

    // R3 half-way tie goes up: gap0 -> target 4
    pulse_dpa_rst();
    run_win(0, 1'b0, 4);
    run_win(0, 1'b0, 4);
    check_eq(phase_sel, 1, "R3 half-way goes up");

    // R2 gap 7 with R10 foreign edges while en low
    pulse_dpa_rst();
    for (int w = 0; w < 4; w++) begin
      run_win(7, 1'b0, 3);
      for (int i = 0; i < 20; i++) drive(mkvec(2, i[0], ~i[0]), 1'b0);
    end
    check_eq(phase_sel, mph, "R10 en-low edges ignored");
    check_eq(phase_sel, 3, "R2 wrap gap7 target");

    // R1 system reset
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check_eq(phase_sel, 0, "R1 phase after second rst");
    check_eq(locked, 0, "R1 lock after second rst");

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule